// File: doc/BRIEF.md
# Share-Serial Masked Simon Datapath

This block runs Simon encryption in bit-serial form on a three-share masked state. In any clock cycle it works on exactly one share. One bit position of the round therefore takes three cycles, and the shares are always updated in the order a, b, c. A single update function is fed through a multiplexer with the operand bits and the key-share bit of the share being updated. A demultiplexer then shifts the result into that share's register, and no other share register moves.

The cross terms are paired in a rotated way. Output a draws on shares a and b, output b on shares b and c, and output c on shares c and a. As a result, only share a has already moved when another share, c, reads it. A one-bit save register keeps the value of share a that its shift pushes off the fixed tap. The surrounding logic loads the masked plaintext shares and pulses start. It then presents the three round-key share bits for the current bit position, holds them for three cycles, and waits for done. XOR-ing the three output shares gives the ciphertext. Key expansion and mask generation are outside this block.

Top module: `tis_serial_simon`

## Requirements
- R1: After reset, done is 0 and all three ciphertext share outputs are 0.
- R2: A load pulse while idle places each share's 2N-bit word into its register, upper N bits left word and lower N bits right word. The ciphertext output of that share reads the word back in the next cycle.
- R3: After a run, the XOR of the three output shares equals Simon encryption, with word width N and ROUNDS rounds, of the XOR of the loaded shares. The round key for round r is the XOR of the three key-share inputs. Bit j of a round uses key bit j of that round.
- R4: done is cleared by an accepted start. It rises exactly 3*N*ROUNDS cycles after the edge that accepts start, and not before.
- R5: In any cycle, at most one share register changes, except for the left/right role swap at the end of a round.
- R6: After start, the updates go to share a, then share b, then share c, repeating once per bit position.
- R7: A start pulse during a run is ignored. Timing and result are unchanged.
- R8: A load pulse during a run is ignored. The run's result is unchanged.
- R9: Two runs with the same recombined plaintext and round keys but different masks give the same recombined ciphertext.
- R10: After done, the outputs and done hold steady until the next load or start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load | input | 1 | Load the three plaintext shares (ignored while running) |
| pt_sh_a | input | 2*N | Plaintext share a, {left, right} |
| pt_sh_b | input | 2*N | Plaintext share b, {left, right} |
| pt_sh_c | input | 2*N | Plaintext share c, {left, right} |
| start | input | 1 | Begin a run (ignored while running or when load is high) |
| ks_a | input | 1 | Round-key share a bit for the current bit position |
| ks_b | input | 1 | Round-key share b bit for the current bit position |
| ks_c | input | 1 | Round-key share c bit for the current bit position |
| done | output | 1 | Run finished, held until the next load or start |
| ct_sh_a | output | 2*N | Output share a, {left, right} |
| ct_sh_b | output | 2*N | Output share b, {left, right} |
| ct_sh_c | output | 2*N | Output share c, {left, right} |

## Verification
The hardest corner is share c reading share a after a has already shifted. Without the save bit, or with a tap that is off by one, the recombined ciphertext would go wrong in the bits whose 8-step rotation wraps, and it would then spread to every bit. The bench watches the share outputs in the first cycles after start. An update order other than a, b, c, or two shares moving in one cycle, shows up as the wrong share output changing. Start and load pulses in the middle of a run must change neither the done time nor the result. A rerun with fresh masks must give the same recombined ciphertext. A key bit taken from the wrong share would break this.

// File: rtl/tis_pkg.sv
package tis_pkg;

  typedef enum logic [1:0] {
    PH_A = 2'd0,
    PH_B = 2'd1,
    PH_C = 2'd2
  } phase_e;

  // operand bits gathered for one share update
  typedef struct packed {
    logic r0;  // right word bit j
    logic l1;  // own left word rotated by 1
    logic l2;  // own left word rotated by 2
    logic l8;  // own left word rotated by 8
    logic o1;  // partner share left word rotated by 1
    logic o8;  // partner share left word rotated by 8
    logic k;   // key share bit
  } taps_t;

  // one output-share bit of the masked round: own quadratic term plus cross terms
  function automatic logic share_bit(input taps_t t);
    return t.r0 ^ t.l2 ^ (t.l1 & t.l8) ^ (t.l1 & t.o8) ^ (t.o1 & t.l8) ^ t.k;
  endfunction

endpackage

// File: rtl/tis_ctrl.sv
module tis_ctrl
  import tis_pkg::*;
#(
  parameter int N      = 64,
  parameter int ROUNDS = 68
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   load,
  input  logic   start,
  output logic   busy,
  output phase_e phase,
  output logic   round_end,
  output logic   load_ok,
  output logic   done
);
  localparam int BW = (N > 1) ? $clog2(N) : 1;
  localparam int RW = (ROUNDS > 1) ? $clog2(ROUNDS) : 1;
  localparam logic [BW-1:0] BIT_LAST = BW'(N - 1);
  localparam logic [RW-1:0] RND_LAST = RW'(ROUNDS - 1);

  logic [BW-1:0] bitc;
  logic [RW-1:0] rnd;
  logic start_ok;
  logic last_step;

  assign load_ok   = load & ~busy;
  assign start_ok  = start & ~busy & ~load;
  assign round_end = busy && phase == PH_C && bitc == BIT_LAST;
  assign last_step = round_end && rnd == RND_LAST;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      phase <= PH_A;
      bitc  <= '0;
      rnd   <= '0;
      done  <= 1'b0;
    end else if (start_ok) begin
      busy  <= 1'b1;
      done  <= 1'b0;
      phase <= PH_A;
      bitc  <= '0;
      rnd   <= '0;
    end else begin
      if (load_ok) done <= 1'b0;
      if (busy) begin
        case (phase)
          PH_A:    phase <= PH_B;
          PH_B:    phase <= PH_C;
          default: begin
            phase <= PH_A;
            if (bitc == BIT_LAST) begin
              bitc <= '0;
              rnd  <= rnd + 1'b1;
            end else begin
              bitc <= bitc + 1'b1;
            end
          end
        endcase
        if (last_step) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  // R4
  done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(busy) && !busy));

  // R7
  run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last_step) |=> busy);

  // R6
  phase_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase inside {PH_A, PH_B, PH_C});

endmodule

// File: rtl/tis_share.sv
module tis_share #(
  parameter int N = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_ok,
  input  logic [2*N-1:0] ld_word,
  input  logic         en,
  input  logic         swap,
  input  logic         newbit,
  output logic         r0,
  output logic         l1,
  output logic         l2,
  output logic         l8,
  output logic [2*N-1:0] word
);
  // two N-bit halves; lsel says which one holds the left word this round
  logic [N-1:0] x0, x1;
  logic         lsel;
  logic [N-1:0] lv, rv;

  assign lv   = lsel ? x1 : x0;
  assign rv   = lsel ? x0 : x1;
  assign r0   = rv[0];
  assign l1   = lv[N-1];
  assign l2   = lv[N-2];
  assign l8   = lv[N-8];
  assign word = {lv, rv};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x0   <= '0;
      x1   <= '0;
      lsel <= 1'b0;
    end else if (load_ok) begin
      x0   <= ld_word[2*N-1:N];
      x1   <= ld_word[N-1:0];
      lsel <= 1'b0;
    end else begin
      if (en) begin
        // left rotates in place, new left bits fill the right half from the top
        if (!lsel) begin
          x0 <= {x0[0], x0[N-1:1]};
          x1 <= {newbit, x1[N-1:1]};
        end else begin
          x1 <= {x1[0], x1[N-1:1]};
          x0 <= {newbit, x0[N-1:1]};
        end
      end
      if (swap) lsel <= ~lsel;
    end
  end

  // R5
  idle_share_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !load_ok) |=> ($stable(x0) && $stable(x1)));

endmodule

// File: rtl/tis_route.sv
module tis_route
  import tis_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       busy,
  input  phase_e     phase,
  input  logic [2:0] r0_v,
  input  logic [2:0] l1_v,
  input  logic [2:0] l2_v,
  input  logic [2:0] l8_v,
  input  logic       ks_a,
  input  logic       ks_b,
  input  logic       ks_c,
  output logic [2:0] en_v,
  output logic       newbit
);
  logic  save_a;  // share a's rotate-by-8 bit from before its shift
  taps_t t;

  assign en_v = busy ? (3'b001 << phase) : 3'b000;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       save_a <= 1'b0;
    else if (en_v[0]) save_a <= l8_v[0];
  end

  always_comb begin
    t = '0;
    case (phase)
      PH_A: begin
        t.r0 = r0_v[0]; t.l1 = l1_v[0]; t.l2 = l2_v[0]; t.l8 = l8_v[0];
        t.o1 = l1_v[1]; t.o8 = l8_v[1]; t.k = ks_a;
      end
      PH_B: begin
        t.r0 = r0_v[1]; t.l1 = l1_v[1]; t.l2 = l2_v[1]; t.l8 = l8_v[1];
        t.o1 = l1_v[2]; t.o8 = l8_v[2]; t.k = ks_b;
      end
      default: begin
        // share a already advanced one place: its rotate-by-1 bit sits on the
        // rotate-by-2 tap, its rotate-by-8 bit is held in save_a
        t.r0 = r0_v[2]; t.l1 = l1_v[2]; t.l2 = l2_v[2]; t.l8 = l8_v[2];
        t.o1 = l2_v[0]; t.o8 = save_a; t.k = ks_c;
      end
    endcase
  end

  assign newbit = share_bit(t);

  // R5
  one_share_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(en_v));

  // R6
  order_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_v[1] |-> $past(en_v[0]));

  // R6
  order_c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_v[2] |-> $past(en_v[1]));

endmodule

// File: rtl/tis_serial_simon.sv
module tis_serial_simon
  import tis_pkg::*;
#(
  parameter int N      = 64,
  parameter int ROUNDS = 68
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [2*N-1:0] pt_sh_a,
  input  logic [2*N-1:0] pt_sh_b,
  input  logic [2*N-1:0] pt_sh_c,
  input  logic           start,
  input  logic           ks_a,
  input  logic           ks_b,
  input  logic           ks_c,
  output logic           done,
  output logic [2*N-1:0] ct_sh_a,
  output logic [2*N-1:0] ct_sh_b,
  output logic [2*N-1:0] ct_sh_c
);
  logic       busy, round_end, load_ok, newbit;
  phase_e     phase;
  logic [2:0] en_v, r0_v, l1_v, l2_v, l8_v;
  logic [2*N-1:0] ld_v   [3];
  logic [2*N-1:0] word_v [3];

  assign ld_v[0] = pt_sh_a;
  assign ld_v[1] = pt_sh_b;
  assign ld_v[2] = pt_sh_c;
  assign ct_sh_a = word_v[0];
  assign ct_sh_b = word_v[1];
  assign ct_sh_c = word_v[2];

  tis_ctrl #(.N(N), .ROUNDS(ROUNDS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .load(load), .start(start),
    .busy(busy), .phase(phase), .round_end(round_end),
    .load_ok(load_ok), .done(done)
  );

  tis_route u_route (
    .clk(clk), .rst_n(rst_n), .busy(busy), .phase(phase),
    .r0_v(r0_v), .l1_v(l1_v), .l2_v(l2_v), .l8_v(l8_v),
    .ks_a(ks_a), .ks_b(ks_b), .ks_c(ks_c),
    .en_v(en_v), .newbit(newbit)
  );

  for (genvar s = 0; s < 3; s++) begin : g_share
    tis_share #(.N(N)) u_sh (
      .clk(clk), .rst_n(rst_n), .load_ok(load_ok), .ld_word(ld_v[s]),
      .en(en_v[s]), .swap(round_end), .newbit(newbit),
      .r0(r0_v[s]), .l1(l1_v[s]), .l2(l2_v[s]), .l8(l8_v[s]),
      .word(word_v[s])
    );
  end

  // R10
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !load && !start) |=> (done && $stable(ct_sh_a) && $stable(ct_sh_b) && $stable(ct_sh_c)));

endmodule

// File: tb/tis_serial_simon_test.sv
`timescale 1ns/1ps
module tis_serial_simon_test;
  localparam int N  = 64;
  localparam int RN = 68;
  localparam int T  = 3 * N * RN;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load = 1'b0, start = 1'b0;
  logic [2*N-1:0] pt_a = '0, pt_b = '0, pt_c = '0;
  logic ks_a = 1'b0, ks_b = 1'b0, ks_c = 1'b0;
  logic done;
  logic [2*N-1:0] ct_a, ct_b, ct_c;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [N-1:0] rk [RN];
  logic [N-1:0] ka [RN];
  logic [N-1:0] kb [RN];
  logic [N-1:0] kc [RN];

  always #2 clk = ~clk;

  tis_serial_simon #(.N(N), .ROUNDS(RN)) uut (
    .clk(clk), .rst_n(rst_n), .load(load),
    .pt_sh_a(pt_a), .pt_sh_b(pt_b), .pt_sh_c(pt_c),
    .start(start), .ks_a(ks_a), .ks_b(ks_b), .ks_c(ks_c),
    .done(done), .ct_sh_a(ct_a), .ct_sh_b(ct_b), .ct_sh_c(ct_c)
  );

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [N-1:0] rol(input logic [N-1:0] x, input int s);
    return (x << s) | (x >> (N - s));
  endfunction

  function automatic logic [N-1:0] ror(input logic [N-1:0] x, input int s);
    return (x >> s) | (x << (N - s));
  endfunction

  function automatic logic [N-1:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  // two-word key expansion, then random three-way split of every round key
  task automatic make_keys(input logic [127:0] key);
    logic [61:0] zc;
    logic [N-1:0] tmp;
    zc = 62'b10101111011100000011010010011000101000010001111110010110110011;
    rk[0] = key[63:0];
    rk[1] = key[127:64];
    for (int i = 0; i < RN - 2; i++) begin
      tmp = ror(rk[i+1], 3);
      tmp = tmp ^ ror(tmp, 1);
      rk[i+2] = ~rk[i] ^ tmp ^ N'(zc[61 - (i % 62)]) ^ N'(3);
    end
    for (int i = 0; i < RN; i++) begin
      ka[i] = rnd64();
      kb[i] = rnd64();
      kc[i] = rk[i] ^ ka[i] ^ kb[i];
    end
  endtask

  function automatic logic [127:0] ref_enc(input logic [127:0] pt);
    logic [N-1:0] x, y, t;
    x = pt[127:64];
    y = pt[63:0];
    for (int r = 0; r < RN; r++) begin
      t = x;
      x = y ^ (rol(x, 1) & rol(x, 8)) ^ rol(x, 2) ^ rk[r];
      y = t;
    end
    return {x, y};
  endfunction

  task automatic run_enc(input logic [127:0] pa, input logic [127:0] pb, input logic [127:0] pc,
                         input bit watch, input bit inject, output logic [127:0] rec);
    logic [127:0] pa_w, pb_w, pc_w;
    logic [2:0] moved, want;
    bit early;
    int step;
    early = 1'b0;
    step = 0;
    @(negedge clk);
    pt_a = pa; pt_b = pb; pt_c = pc; load = 1'b1;
    @(negedge clk);
    load = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b0, "R4 done cleared by start", 128'(done), 128'd0);
    for (int r = 0; r < RN; r++) begin
      for (int j = 0; j < N; j++) begin
        ks_a = ka[r][j]; ks_b = kb[r][j]; ks_c = kc[r][j];
        for (int p = 0; p < 3; p++) begin
          pa_w = ct_a; pb_w = ct_b; pc_w = ct_c;
          if (inject && r == 5 && j == 3 && p == 0) begin
            start = 1'b1; load = 1'b1;
            pt_a = ~pa; pt_b = pa ^ pb; pt_c = '1;
          end
          @(posedge clk);
          @(negedge clk);
          start = 1'b0; load = 1'b0;
          step++;
          if (step < T && done) early = 1'b1;
          if (watch && step <= 6) begin
            moved = {ct_c != pc_w, ct_b != pb_w, ct_a != pa_w};
            want = 3'b001 << ((step - 1) % 3);
            chk(moved == want, "R5/R6 one share per cycle in order a,b,c", 128'(moved), 128'(want));
          end
        end
      end
    end
    chk(!early, "R4 done not before last step", 128'(early), 128'd0);
    chk(done == 1'b1, "R4 done after 3*N*ROUNDS cycles", 128'(done), 128'd1);
    rec = ct_a ^ ct_b ^ ct_c;
  endtask

  task automatic t_reset();
    chk(done == 1'b0, "R1 done low after reset", 128'(done), 128'd0);
    chk((ct_a | ct_b | ct_c) == '0, "R1 outputs zero after reset", ct_a | ct_b | ct_c, 128'd0);
  endtask

  task automatic t_load();
    logic [127:0] a, b, c;
    a = {rnd64(), rnd64()}; b = {rnd64(), rnd64()}; c = {rnd64(), rnd64()};
    @(negedge clk);
    pt_a = a; pt_b = b; pt_c = c; load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    chk(ct_a == a, "R2 share a readback", ct_a, a);
    chk(ct_b == b, "R2 share b readback", ct_b, b);
    chk(ct_c == c, "R2 share c readback", ct_c, c);
  endtask

  task automatic t_masks_and_order();
    logic [127:0] pt, key, m1, m2, rec1, rec2, exp, sa1;
    pt  = {rnd64(), rnd64()};
    key = {rnd64(), rnd64()};
    make_keys(key);
    exp = ref_enc(pt);
    m1 = {rnd64(), rnd64()}; m2 = {rnd64(), rnd64()};
    run_enc(m1, m2, pt ^ m1 ^ m2, 1'b1, 1'b0, rec1);
    chk(rec1 == exp, "R3 recombined ciphertext", rec1, exp);
    sa1 = ct_a;
    m1 = {rnd64(), rnd64()}; m2 = {rnd64(), rnd64()};
    run_enc(m1, m2, pt ^ m1 ^ m2, 1'b0, 1'b0, rec2);
    chk(rec2 == rec1, "R9 same result under fresh masks", rec2, rec1);
    chk(ct_a != sa1, "R9 individual share differs under fresh masks", ct_a, sa1);
  endtask

  task automatic t_inject();
    logic [127:0] pt, m1, m2, rec, exp;
    pt = {rnd64(), rnd64()};
    make_keys({rnd64(), rnd64()});
    exp = ref_enc(pt);
    m1 = {rnd64(), rnd64()}; m2 = {rnd64(), rnd64()};
    run_enc(m1, m2, pt ^ m1 ^ m2, 1'b0, 1'b1, rec);
    chk(rec == exp, "R7/R8 start and load mid-run ignored", rec, exp);
  endtask

  task automatic t_hold();
    logic [127:0] a, b, c;
    a = ct_a; b = ct_b; c = ct_c;
    repeat (20) @(negedge clk);
    chk(done == 1'b1, "R10 done holds", 128'(done), 128'd1);
    chk(ct_a == a && ct_b == b && ct_c == c, "R10 outputs hold", ct_a ^ ct_b ^ ct_c, a ^ b ^ c);
  endtask

  task automatic t_zero_pt();
    logic [127:0] m1, m2, rec, exp;
    make_keys(128'h0f0e0d0c0b0a0908_0706050403020100);
    exp = ref_enc(128'd0);
    m1 = {rnd64(), rnd64()}; m2 = {rnd64(), rnd64()};
    run_enc(m1, m2, m1 ^ m2, 1'b0, 1'b0, rec);
    chk(rec == exp, "R3 zero plaintext", rec, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_load();
    t_masks_and_order();
    t_hold();
    t_inject();
    t_zero_pt();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule